// File: doc/BRIEF.md
# Glitch-Free Sawtooth PWM Timer

This block is a single-slope PWM generator. An up-counter runs from zero to a programmable ceiling held in a period register, then returns to zero, so the period register alone sets the PWM frequency. Two compare channels each drive one output pin. A channel's pin goes high at the start of each period and drops once the count passes that channel's compare value. A per-channel invert bit flips the waveform.

Software may rewrite a compare value at any moment without stopping the counter. The write goes to a holding register. The working compare register, which alone decides the pin level, copies the holding register only on the clock edge where the counter returns to zero. The period in progress therefore always finishes with its old duty, and no runt or stretched pulse appears.

An overflow flag records each return to zero. It stays set until software clears it. Configuration goes through a small single-cycle write port.

Top module: `sawtooth_pwm`

## Requirements
- R1: The counter increments by one each clock. On the clock edge where the count is greater than or equal to the period register, it loads 0 instead. One period therefore lasts period+1 clocks. The period register is written at address 0.
- R2: On every clock edge where the counter loads 0 (the wrap), the overflow flag is set. The flag is visible in the following cycle.
- R3: The overflow flag stays set until a cycle with `ovf_clr` high clears it. If a wrap and `ovf_clr` fall in the same cycle, the flag ends set.
- R4: In non-inverting mode, an enabled pin is high while the count is less than or equal to the working compare value, and low otherwise.
- R5: With the channel's invert bit set, the enabled pin is the complement of the R4 waveform.
- R6: A compare value of 0 gives a high pulse one clock wide in each period. A compare value equal to or above the period keeps the pin high for the whole period.
- R7: Writes go to holding registers: channel A at address 1, channel B at address 2. A working compare register loads from its holding register only on a wrap edge. A write made mid-period leaves the rest of that period unchanged, and the new duty appears from the next period on.
- R8: The control register at address 3 holds four bits: bit 0 enables A, bit 1 inverts A, bit 2 enables B, bit 3 inverts B. A pin whose enable bit is 0 stays low whatever its compare value and invert bit are.
- R9: While `rst_n` is low, the counter, period, holding registers, working registers, control bits and flag are all zero. Both pins and the flag read low.
- R10: Suppose the period is rewritten to a value below the current count. The counter then wraps to 0 on the clock edge after the write edge, and this wrap also sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 compare A, 2 compare B, 3 control |
| wr_data | input | W | Write data (control uses bits 3:0) |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky wrap indication |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
The duty function is exercised with a mid-range compare value on a non-inverting channel and another on an inverting channel. This separates the polarity handling from the compare boundary at "less than or equal". Compare values of 0, equal to the period and above the period probe the two saturation edges. A compare rewrite in the middle of a period shows whether the old duty survives to the wrap and the new one takes over after it. Disabled channels, a period shrink below the running count, and a clear that collides with a wrap round out the cases.

// File: rtl/sawtooth_pwm.sv
module sawtooth_pwm #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         ovf_clr,
  output logic         ovf_flag,
  output logic         pwm_a,
  output logic         pwm_b
);

  localparam logic [1:0] ADDR_PER  = 2'd0;
  localparam logic [1:0] ADDR_CMPA = 2'd1;
  localparam logic [1:0] ADDR_CMPB = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  logic [W-1:0] cnt, per;
  logic [W-1:0] hold_a, hold_b, work_a, work_b;
  logic [3:0]   ctrl;
  logic         wrap;

  assign wrap = (cnt >= per);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      per      <= '0;
      hold_a   <= '0;
      hold_b   <= '0;
      work_a   <= '0;
      work_b   <= '0;
      ctrl     <= '0;
      ovf_flag <= 1'b0;
    end else begin
      cnt      <= wrap ? '0 : cnt + 1'b1;
      ovf_flag <= wrap | (ovf_flag & ~ovf_clr);
      if (wrap) begin
        work_a <= hold_a;
        work_b <= hold_b;
      end
      if (wr_en) begin
        case (wr_addr)
          ADDR_PER:  per    <= wr_data;
          ADDR_CMPA: hold_a <= wr_data;
          ADDR_CMPB: hold_b <= wr_data;
          ADDR_CTRL: ctrl   <= wr_data[3:0];
          default:   ;
        endcase
      end
    end
  end

  assign pwm_a = ctrl[0] & ((cnt <= work_a) ^ ctrl[1]);
  assign pwm_b = ctrl[2] & ((cnt <= work_b) ^ ctrl[3]);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> cnt == $past(cnt) + 1'b1);
  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  // R2
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R7
  work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(work_a) && $stable(work_b)));
  // R8
  pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] |-> !pwm_a) and (!ctrl[2] |-> !pwm_b));

endmodule

// File: tb/sawtooth_pwm_tb_top.sv
module sawtooth_pwm_tb_top;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ovf_clr = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic ovf_flag, pwm_a, pwm_b;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sawtooth_pwm #(.W(W)) dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .ovf_flag(ovf_flag), .pwm_a(pwm_a), .pwm_b(pwm_b));

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_pulse();
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  // returns at a negedge where the count is 0
  task automatic sync();
    clr_pulse();
    while (!ovf_flag) @(negedge clk);
  endtask

  task automatic run_period(string req, int top, int ca, bit ea, bit ia,
                            int cb, bit eb, bit ib);
    for (int k = 0; k <= top; k++) begin
      check({req, " pin A"}, pwm_a, ea & ((k <= ca) ^ ia));
      check({req, " pin B"}, pwm_b, eb & ((k <= cb) ^ ib));
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 pin A in reset", pwm_a, 1'b0);
    check("R9 pin B in reset", pwm_b, 1'b0);
    check("R9 flag in reset", ovf_flag, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_duty();
    wr(2'd0, 9); wr(2'd1, 3); wr(2'd2, 6); wr(2'd3, 'hD);
    sync();
    run_period("R4/R5 duty", 9, 3, 1, 0, 6, 1, 1);
    run_period("R1 next period", 9, 3, 1, 0, 6, 1, 1);
  endtask

  task automatic t_buffer();
    sync();
    for (int k = 0; k < 2; k++) begin
      check("R7 lead-in", pwm_a, k <= 3);
      @(negedge clk);
    end
    check("R7 at write", pwm_a, 1'b1);
    wr(2'd1, 8);
    for (int k = 3; k <= 9; k++) begin
      check("R7 old duty kept", pwm_a, k <= 3);
      @(negedge clk);
    end
    run_period("R7 new duty", 9, 8, 1, 0, 6, 1, 1);
  endtask

  task automatic t_edges();
    wr(2'd1, 0); sync();
    run_period("R6 compare zero", 9, 0, 1, 0, 6, 1, 1);
    wr(2'd1, 9); sync();
    run_period("R6 compare at top", 9, 9, 1, 0, 6, 1, 1);
    wr(2'd1, 20); sync();
    run_period("R6 compare above top", 9, 20, 1, 0, 6, 1, 1);
  endtask

  task automatic t_disable();
    wr(2'd3, 'h2); wr(2'd1, 4); sync();
    run_period("R8 disabled", 9, 4, 0, 1, 6, 0, 1);
    wr(2'd3, 'hD);
  endtask

  task automatic t_flag();
    sync();
    clr_pulse();
    check("R3 cleared", ovf_flag, 1'b0);
    for (int k = 1; k < 9; k++) @(negedge clk);
    check("R2 not yet set", ovf_flag, 1'b0);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R3 set wins over clear", ovf_flag, 1'b1);
    repeat (5) @(negedge clk);
    check("R3 sticky", ovf_flag, 1'b1);
  endtask

  task automatic t_shrink();
    sync();
    for (int k = 0; k < 6; k++) @(negedge clk);
    clr_pulse();
    check("R10 flag cleared", ovf_flag, 1'b0);
    wr(2'd0, 3);
    check("R10 no wrap on write edge", ovf_flag, 1'b0);
    @(negedge clk);
    check("R10 wrap after shrink", ovf_flag, 1'b1);
    run_period("R10 short period", 3, 8, 1, 0, 6, 1, 1);
    clr_pulse();
    @(negedge clk); @(negedge clk);
    check("R2 mid short period", ovf_flag, 1'b0);
    @(negedge clk);
    check("R2 short period wrap", ovf_flag, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_duty();
    t_buffer();
    t_edges();
    t_disable();
    t_flag();
    t_shrink();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule